// File: doc/BRIEF.md
# Four-channel DMA request dispatcher

This block is the register front end and request router that sits in front of four DMA transfer engines. Software programs each channel through a small register window. Each channel has a source address, a destination address, a 24-bit unit count and a control word. One shared operation register follows the last channel group. The dispatcher holds no datapath of its own. A transfer engine is reached only through a one-cycle start strobe, and it reports completion back through an end strobe.

Request events arrive as single-cycle pulses on six separate inputs: an external request, transmit-empty and receive-full from a plain serial port, the same two from a FIFO-buffered serial port, and a timer tick. On every pulse the dispatcher compares each channel's 4-bit resource code, held in control bits 11:8, against the event. Every channel that matches and is live receives a start for exactly one unit. Each channel also drives a level interrupt. The interrupt is high while both its interrupt-enable bit and its transfer-end bit are set.

Top module: `dma_req_dispatch`

## Requirements
- R1: The register window is addressed by a 12-bit byte address. Channel n owns the group at n*0x10: source at +0x0, destination at +0x4, count at +0x8 and control at +0xC. The operation register sits at 0x040. A write with address bits 1:0 not zero, or to any other location, changes nothing.
- R2: The count register stores 24 bits and reads back with bits 31:24 as zero.
- R3: A read returns the stored value of the addressed register on the same cycle. Reset clears every register. Unmapped and misaligned reads return zero.
- R4: An external request pulse starts every live channel whose resource code is 0x0.
- R5: The serial events start only channels with an exactly matching code: 0x8 for serial transmit-empty, 0x9 for serial receive-full, 0xA for FIFO transmit-empty and 0xB for FIFO receive-full.
- R6: A timer pulse starts every live channel whose code is 0xC or higher.
- R7: Channels with codes 0x1 to 0x7 never receive a start from any event. This covers the self-requesting codes 0x4 to 0x7.
- R8: No start is issued unless bits 2:0 of the operation register equal 3'b001. The other bits of that register do not matter.
- R9: A channel is live only when control bit 0 (enable) is 1 and bit 1 (transfer end) is 0. Liveness is judged separately for each channel.
- R10: A start is a one-cycle pulse on the cycle after the event pulse. Events that arrive together start the union of their matching channels in that same cycle.
- R11: A pulse on a channel's end input sets control bit 1 of that channel. The bit stays set until software writes it clear.
- R12: A channel's interrupt is high while control bit 2 (interrupt enable) and bit 1 are both 1. It drops on the cycle after a control write clears either bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| ev_ext | input | 1 | External request pulse |
| ev_ser_tx | input | 1 | Serial transmit-empty pulse |
| ev_ser_rx | input | 1 | Serial receive-full pulse |
| ev_fifo_tx | input | 1 | FIFO serial transmit-empty pulse |
| ev_fifo_rx | input | 1 | FIFO serial receive-full pulse |
| ev_tmr | input | 1 | Timer tick pulse |
| xfer_end | input | 4 | Per-channel end strobe from the engines |
| start | output | 4 | Per-channel one-unit start strobe |
| irq | output | 4 | Per-channel interrupt level |

## Verification
The bench builds the block with its defaults: four channels, a 12-bit window and a 24-bit count. With these values all sixteen resource codes can be spread across the channels within a handful of vectors. The count width leaves exactly one byte above the count field to check for zeros. The operation register lands at 0x040, immediately past the last channel group, so the directed reads can probe the edge between a valid group and unmapped space.

// File: rtl/dmad_pkg.sv
package dmad_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SLOT_SRC = 2'd0,
        SLOT_DST = 2'd1,
        SLOT_CNT = 2'd2,
        SLOT_CTL = 2'd3
    } slot_e;

    localparam logic [3:0] CODE_EXT     = 4'h0;
    localparam logic [3:0] CODE_SER_TX  = 4'h8;
    localparam logic [3:0] CODE_SER_RX  = 4'h9;
    localparam logic [3:0] CODE_FIFO_TX = 4'hA;
    localparam logic [3:0] CODE_FIFO_RX = 4'hB;
    localparam logic [3:0] CODE_TMR_MIN = 4'hC;

    typedef struct packed {
        logic tmr;
        logic fifo_rx;
        logic fifo_tx;
        logic ser_rx;
        logic ser_tx;
        logic ext;
    } evt_t;

    typedef struct packed {
        logic ie;
        logic te;
        logic de;
    } flags_t;

    function automatic logic code_hit(input logic [3:0] code, input evt_t ev);
        return (ev.ext     && code == CODE_EXT)
            || (ev.ser_tx  && code == CODE_SER_TX)
            || (ev.ser_rx  && code == CODE_SER_RX)
            || (ev.fifo_tx && code == CODE_FIFO_TX)
            || (ev.fifo_rx && code == CODE_FIFO_RX)
            || (ev.tmr     && code >= CODE_TMR_MIN);
    endfunction

    function automatic logic chan_live(input flags_t f);
        return f.de && !f.te;
    endfunction

    function automatic logic glob_live(input logic [2:0] op);
        return op == 3'b001;
    endfunction

endpackage

// File: rtl/dmad_regs.sv
module dmad_regs
    import dmad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LOC_W  = 12,
    parameter int CNT_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [LOC_W-1:0]        addr,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]       xfer_end,
    output logic [REG_W-1:0]        rd_data,
    output logic [NUM_CH-1:0][3:0]  ch_code,
    output flags_t [NUM_CH-1:0]     ch_flags,
    output logic [2:0]              op_low
);
    localparam int SEL_W = LOC_W - 4;
    localparam logic [LOC_W-1:0] OP_LOC = LOC_W'(NUM_CH * 16);

    logic [SEL_W-1:0] sel;
    slot_e            slot;
    logic             aligned;
    logic [REG_W-1:0] op_q;
    logic [NUM_CH-1:0][REG_W-1:0] chan_rd;

    assign sel     = addr[LOC_W-1:4];
    assign slot    = slot_e'(addr[3:2]);
    assign aligned = (addr[1:0] == 2'b00);
    assign op_low  = op_q[2:0];

    always_ff @(posedge clk) begin
        if (rst)
            op_q <= '0;
        else if (wr_en && addr == OP_LOC)
            op_q <= wr_data;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [REG_W-1:0] src_q, dst_q, ctl_q, ctl_nxt, view;
        logic [CNT_W-1:0] cnt_q;
        logic             hit;

        assign hit = wr_en && aligned && (sel == SEL_W'(g));

        always_comb begin
            ctl_nxt = ctl_q;
            if (hit && slot == SLOT_CTL)
                ctl_nxt = wr_data;
            if (xfer_end[g])
                ctl_nxt[1] = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q <= '0;
                dst_q <= '0;
                cnt_q <= '0;
                ctl_q <= '0;
            end else begin
                if (hit && slot == SLOT_SRC) src_q <= wr_data;
                if (hit && slot == SLOT_DST) dst_q <= wr_data;
                if (hit && slot == SLOT_CNT) cnt_q <= wr_data[CNT_W-1:0];
                ctl_q <= ctl_nxt;
            end
        end

        always_comb begin
            case (slot)
                SLOT_SRC: view = src_q;
                SLOT_DST: view = dst_q;
                SLOT_CNT: view = {{(REG_W-CNT_W){1'b0}}, cnt_q};
                default:  view = ctl_q;
            endcase
        end

        assign chan_rd[g]  = view;
        assign ch_code[g]  = ctl_q[11:8];
        assign ch_flags[g] = flags_t'(ctl_q[2:0]);
    end

    always_comb begin
        rd_data = '0;
        if (addr == OP_LOC)
            rd_data = op_q;
        for (int i = 0; i < NUM_CH; i++)
            if (aligned && sel == SEL_W'(i))
                rd_data = chan_rd[i];
    end

endmodule

// File: rtl/dmad_route.sv
module dmad_route
    import dmad_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   glob_en,
    input  evt_t                   ev,
    input  logic [NUM_CH-1:0][3:0] ch_code,
    input  logic [NUM_CH-1:0]      ch_live,
    output logic [NUM_CH-1:0]      start
);
    logic [NUM_CH-1:0] fire;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_match
        assign fire[g] = glob_en && ch_live[g] && code_hit(ch_code[g], ev);
    end

    always_ff @(posedge clk) begin
        if (rst)
            start <= '0;
        else
            start <= fire;
    end

endmodule

// File: rtl/dma_req_dispatch.sv
module dma_req_dispatch
    import dmad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LOC_W  = 12,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LOC_W-1:0]  addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              ev_ext,
    input  logic              ev_ser_tx,
    input  logic              ev_ser_rx,
    input  logic              ev_fifo_tx,
    input  logic              ev_fifo_rx,
    input  logic              ev_tmr,
    input  logic [NUM_CH-1:0] xfer_end,
    output logic [NUM_CH-1:0] start,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0][3:0] ch_code;
    flags_t [NUM_CH-1:0]    ch_flags;
    logic [2:0]             op_low;
    logic                   glob_en;
    logic [NUM_CH-1:0]      ch_live;
    evt_t                   evt;

    assign evt     = '{tmr: ev_tmr, fifo_rx: ev_fifo_rx, fifo_tx: ev_fifo_tx,
                       ser_rx: ev_ser_rx, ser_tx: ev_ser_tx, ext: ev_ext};
    assign glob_en = glob_live(op_low);

    dmad_regs #(.NUM_CH(NUM_CH), .LOC_W(LOC_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .xfer_end (xfer_end),
        .rd_data  (rd_data),
        .ch_code  (ch_code),
        .ch_flags (ch_flags),
        .op_low   (op_low)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
        assign ch_live[g] = chan_live(ch_flags[g]);
        assign irq[g]     = ch_flags[g].ie && ch_flags[g].te;
    end

    dmad_route #(.NUM_CH(NUM_CH)) u_route (
        .clk     (clk),
        .rst     (rst),
        .glob_en (glob_en),
        .ev      (evt),
        .ch_code (ch_code),
        .ch_live (ch_live),
        .start   (start)
    );

endmodule

// File: rtl/dmad_checker.sv
module dmad_checker #(
    parameter int NUM_CH = 4,
    parameter int LOC_W  = 12
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [LOC_W-1:0]       addr,
    input logic [7:0]             rd_hi,
    input logic                   ev_any,
    input logic [NUM_CH-1:0]      xfer_end,
    input logic [NUM_CH-1:0]      start,
    input logic [NUM_CH-1:0]      irq,
    input logic                   glob_en,
    input logic [NUM_CH-1:0]      ch_live,
    input logic [NUM_CH-1:0][3:0] ch_code
);
    assert_cnt_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (addr[3:0] == 4'h8 && addr[LOC_W-1:4] < NUM_CH) |-> rd_hi == 8'h00);

    assert_glob_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (|start) |-> $past(glob_en));

    assert_needs_event_R10: assert property (@(posedge clk) disable iff (rst)
        (|start) |-> $past(ev_any));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_live_R9: assert property (@(posedge clk) disable iff (rst)
            start[g] |-> $past(ch_live[g]));

        assert_no_auto_R7: assert property (@(posedge clk) disable iff (rst)
            start[g] |-> $past(ch_code[g] == 4'h0 || ch_code[g] >= 4'h8));

        assert_irq_cause_R12: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[g]) |-> ($past(xfer_end[g]) || $past(wr_en)));
    end

endmodule

bind dma_req_dispatch dmad_checker #(.NUM_CH(NUM_CH), .LOC_W(LOC_W)) u_dmad_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .rd_hi    (rd_data[31:24]),
    .ev_any   (ev_ext | ev_ser_tx | ev_ser_rx | ev_fifo_tx | ev_fifo_rx | ev_tmr),
    .xfer_end (xfer_end),
    .start    (start),
    .irq      (irq),
    .glob_en  (glob_en),
    .ch_live  (ch_live),
    .ch_code  (ch_code)
);

// File: tb/dma_req_dispatch_bench.sv
`timescale 1ns/1ps
module dma_req_dispatch_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ev_ext = 0, ev_ser_tx = 0, ev_ser_rx = 0;
    logic        ev_fifo_tx = 0, ev_fifo_rx = 0, ev_tmr = 0;
    logic [3:0]  xfer_end = '0;
    logic [3:0]  start, irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_req_dispatch u_dma_req_dispatch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .ev_ext(ev_ext), .ev_ser_tx(ev_ser_tx),
        .ev_ser_rx(ev_ser_rx), .ev_fifo_tx(ev_fifo_tx), .ev_fifo_rx(ev_fifo_rx),
        .ev_tmr(ev_tmr), .xfer_end(xfer_end), .start(start), .irq(irq)
    );

    // Vector: {codes ch3..ch0 (16), event mask {tmr,frx,ftx,srx,stx,ext} (6), expected start (4)}
    localparam logic [25:0] VEC [10] = '{
        {16'h008C, 6'b000001, 4'b1100},
        {16'h008C, 6'b100000, 4'b0001},
        {16'h89AB, 6'b000010, 4'b1000},
        {16'h89AB, 6'b010100, 4'b0101},
        {16'h89AB, 6'b001000, 4'b0010},
        {16'hCDEF, 6'b100000, 4'b1111},
        {16'h4567, 6'b111111, 4'b0000},
        {16'h0123, 6'b000001, 4'b1000},
        {16'h0123, 6'b000000, 4'b0000},
        {16'hBA98, 6'b111111, 4'b1111}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    task automatic pulse(input logic [5:0] m);
        @(negedge clk);
        {ev_tmr, ev_fifo_rx, ev_fifo_tx, ev_ser_rx, ev_ser_tx, ev_ext} = m;
        @(negedge clk);
        {ev_tmr, ev_fifo_rx, ev_fifo_tx, ev_ser_rx, ev_ser_tx, ev_ext} = '0;
    endtask

    task automatic end_pulse(input logic [3:0] m);
        @(negedge clk);
        xfer_end = m;
        @(negedge clk);
        xfer_end = '0;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 reset state
        check(start === 4'b0, "R3 reset start", 32'(start), 0);
        check(irq === 4'b0, "R3 reset irq", 32'(irq), 0);
        rd_chk(12'h00C, 32'h0, "R3 reset ctrl");
        rd_chk(12'h040, 32'h0, "R3 reset op");

        wr(12'h040, 32'h1);
        // Vector walk: R4 R5 R6 R7 R10
        for (int k = 0; k < 10; k++) begin
            for (int c = 0; c < 4; c++)
                wr(12'(c * 16 + 12), {20'h0, VEC[k][10 + c*4 +: 4], 8'h01});
            pulse(VEC[k][9:4]);
            check(start === VEC[k][3:0], $sformatf("R4 R5 R6 R7 R10 vector %0d", k),
                  32'(start), 32'(VEC[k][3:0]));
            @(negedge clk);
            check(start === 4'b0, $sformatf("R10 single pulse vector %0d", k),
                  32'(start), 0);
        end

        // R8 global enable
        for (int c = 0; c < 4; c++) wr(12'(c * 16 + 12), 32'h0);
        wr(12'h00C, 32'h0000_0001);
        wr(12'h040, 32'h0);
        pulse(6'b000001);
        check(start === 4'b0, "R8 op zero", 32'(start), 0);
        wr(12'h040, 32'h3);
        pulse(6'b000001);
        check(start === 4'b0, "R8 op 011", 32'(start), 0);
        wr(12'h040, 32'h9);
        pulse(6'b000001);
        check(start === 4'b0001, "R8 op upper bits ignored", 32'(start), 1);

        // R9 channel liveness
        wr(12'h00C, 32'h0000_0003);
        pulse(6'b000001);
        check(start === 4'b0, "R9 end bit blocks", 32'(start), 0);
        wr(12'h00C, 32'h0000_0000);
        pulse(6'b000001);
        check(start === 4'b0, "R9 enable clear", 32'(start), 0);

        // R11 R12 end and interrupt
        wr(12'h01C, 32'h0000_0805);
        check(irq === 4'b0, "R12 no end yet", 32'(irq), 0);
        end_pulse(4'b0010);
        check(irq === 4'b0010, "R12 irq after end", 32'(irq), 32'h2);
        rd_chk(12'h01C, 32'h0000_0807, "R11 end bit set");
        pulse(6'b000010);
        check(start === 4'b0, "R9 ended channel idle", 32'(start), 0);
        wr(12'h01C, 32'h0000_0803);
        check(irq === 4'b0, "R12 enable cleared", 32'(irq), 0);
        wr(12'h01C, 32'h0000_0807);
        check(irq === 4'b0010, "R12 both set by write", 32'(irq), 32'h2);
        wr(12'h01C, 32'h0000_0805);
        check(irq === 4'b0, "R12 end cleared", 32'(irq), 0);

        // R1 R3 map and read-back
        wr(12'h020, 32'hDEAD_BEEF);
        wr(12'h034, 32'h1234_5678);
        rd_chk(12'h020, 32'hDEAD_BEEF, "R1 ch2 source");
        rd_chk(12'h034, 32'h1234_5678, "R1 ch3 destination");
        rd_chk(12'h024, 32'h0, "R1 ch2 destination untouched");
        rd_chk(12'h050, 32'h0, "R3 unmapped read");
        wr(12'h021, 32'h5555_5555);
        rd_chk(12'h020, 32'hDEAD_BEEF, "R1 misaligned write ignored");
        rd_chk(12'h040, 32'h9, "R3 op read");

        // R2 count width
        wr(12'h008, 32'hFFFF_FFFF);
        rd_chk(12'h008, 32'h00FF_FFFF, "R2 count upper zero");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule